// File: doc/BRIEF.md
# Pipelined Rearrangeable Permutation Network

This block reorders a vector of equal-width data lanes on every clock cycle. The lane count is a power of two. The vector passes through a rearrangeable network of two-by-two exchange elements, and a register follows every column of elements. Each column takes one select bit per element. A select of zero passes the pair straight through. A select of one swaps the pair.

The select bits do not come from the ports. A small route store holds precomputed routing words, and software or a compiler computes the routes offline and writes them in. Each vector offered at the input takes the route word at the replay pointer. The pointer then steps to the next entry, so a scheduled series of permutations plays back one vector per cycle. Each column's slice of the route word is delayed until the vector it belongs to reaches that column. As a result, back-to-back vectors can use different routes, and results appear after a fixed latency. A restart input rewinds the playback to the first entry.

Top module: `benes_permuter`

## Requirements
- R1: The block has N = 2^LOG2_LANES lanes of W bits each. Lane i occupies bits [i*W +: W] of both the input and the output vector.
- R2: The network has 2*LOG2_LANES-1 columns with N/2 elements each. Element k of column s pairs two lanes whose addresses differ only in bit b(s). For s < LOG2_LANES, b(s) = LOG2_LANES-1-s; otherwise b(s) = s-LOG2_LANES+1. The lower lane of the pair is k with a 0 inserted at bit b(s). The select of element k in column s is bit s*(N/2)+k of the route word. As a consequence, crossing every element of the column for bit b maps output lane i to input lane i XOR 2^b.
- R3: A select of 0 passes each lane of the pair through unchanged. A select of 1 swaps the two lanes.
- R4: An all-zero route word gives the identity. A route word that crosses every element of columns 0 to LOG2_LANES-1 and none of the rest gives the reversal, out[i] = in[N-1-i].
- R5: out_valid rises exactly 2*LOG2_LANES-1 cycles after the cycle in which in_valid was high, carrying that vector. Idle input cycles give idle output cycles at the same spacing.
- R6: Each vector is permuted by the route word read in its own entry cycle, even when a different route is used on every consecutive cycle.
- R7: A write of route_data to route entry route_addr while route_we is high applies to vectors offered from the next cycle on. Route entries keep their contents through reset.
- R8: The replay pointer advances by one for each cycle with in_valid high, holds in idle cycles, and wraps from ROUTE_DEPTH-1 to 0.
- R9: A vector offered with restart high uses entry 0, and the next vector uses entry 1.
- R10: After reset, out_valid is low and the replay pointer is at entry 0.
- R11: Every output vector contains each input word exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_we | input | 1 | Write strobe for the route store |
| route_addr | input | $clog2(ROUTE_DEPTH) | Route entry to write |
| route_data | input | (2*LOG2_LANES-1)*N/2 | Routing word to store |
| restart | input | 1 | Rewind playback to entry 0 for this cycle's vector |
| in_valid | input | 1 | Input vector present |
| in_data | input | N*W | Input lanes |
| out_valid | output | 1 | Output vector present |
| out_data | output | N*W | Permuted lanes |

## Verification
If a column's select delay is wrong, or the replay pointer is off by one, a vector leaves with another vector's route. This shows up as a mismatched output vector at the end of the fixed latency, first in a stream that switches route every cycle. A valid bit that is lost or duplicated inside the pipeline shows as an out_valid pulse in the wrong cycle. A swapped lane wire duplicates or drops an input word, and the per-vector content check catches this on the first vector that uses that element. Directed identity, reversal, single-element and address-bit patterns locate such faults, and random routes with random gaps and restarts cover the mixtures.

// File: rtl/benes_pkg.sv
package benes_pkg;

   // address bit exchanged by column s of a network with n address bits
   function automatic int col_bit(input int s, input int n);
      return (s < n) ? (n - 1 - s) : (s - n + 1);
   endfunction

   // lower lane of element k when lanes differing in bit b are paired
   function automatic int pair_low(input int k, input int b);
      return ((k >> b) << (b + 1)) | (k & ((1 << b) - 1));
   endfunction

endpackage

// File: rtl/benes_switch.sv
module benes_switch #(
   parameter int W = 8
) (
   input  logic         sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] x,
   output logic [W-1:0] y
);
   assign x = sel ? b : a;
   assign y = sel ? a : b;
endmodule

// File: rtl/benes_ctrl_delay.sv
module benes_ctrl_delay #(
   parameter int WIDTH = 4,
   parameter int DLY   = 1
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (DLY == 0) begin : g_wire
         assign q = d;
      end else begin : g_pipe
         logic [WIDTH-1:0] tap [DLY];
         always_ff @(posedge clk) begin
            tap[0] <= d;
            for (int i = 1; i < DLY; i++) tap[i] <= tap[i-1];
         end
         assign q = tap[DLY-1];
      end
   endgenerate
endmodule

// File: rtl/benes_column.sv
module benes_column #(
   parameter int N   = 8,
   parameter int W   = 8,
   parameter int BIT = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_data,
   input  logic [N/2-1:0] sel,
   output logic           out_valid,
   output logic [N*W-1:0] out_data
);
   localparam int SW = N / 2;

   if ((1 << BIT) >= N) begin : g_bad_bit
      $error("benes_column: BIT out of range");
   end

   logic [N*W-1:0] swapped;

   for (genvar k = 0; k < SW; k++) begin : g_elem
      localparam int LO = benes_pkg::pair_low(k, BIT);
      localparam int HI = LO + (1 << BIT);
      benes_switch #(.W(W)) u_sw (
         .sel (sel[k]),
         .a   (in_data[LO*W +: W]),
         .b   (in_data[HI*W +: W]),
         .x   (swapped[LO*W +: W]),
         .y   (swapped[HI*W +: W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) out_data <= swapped;

   // column keeps the lane content: XOR over all lanes is unchanged
   logic [W-1:0] fold_in, fold_out;
   always_comb begin
      fold_in  = '0;
      fold_out = '0;
      for (int i = 0; i < N; i++) begin
         fold_in  = fold_in  ^ in_data[i*W +: W];
         fold_out = fold_out ^ out_data[i*W +: W];
      end
   end

   p_lane_content_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (fold_out == $past(fold_in)));
endmodule

// File: rtl/benes_route_mem.sv
module benes_route_mem #(
   parameter int DEPTH = 16,
   parameter int CW    = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [CW-1:0]            wdata,
   input  logic                     restart,
   input  logic                     advance,
   output logic [CW-1:0]            route
);
   localparam int AW = $clog2(DEPTH);

   logic [CW-1:0] store [DEPTH];
   logic [AW-1:0] ptr, rd_addr;

   assign rd_addr = restart ? '0 : ptr;
   assign route   = store[rd_addr];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= rd_addr + 1'b1;
      else              ptr <= rd_addr;
   end

   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart) |=> (ptr == $past(ptr) + 1'b1));
   p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(ptr));
   p_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && advance) |=> (ptr == AW'(1)));
   p_reset_ptr_r10: assert property (@(posedge clk)
      !rst_n |-> (ptr == '0));
endmodule

// File: rtl/benes_permuter.sv
module benes_permuter #(
   parameter int LOG2_LANES  = 3,
   parameter int W           = 8,
   parameter int ROUTE_DEPTH = 16,
   localparam int N      = 1 << LOG2_LANES,
   localparam int SW     = N / 2,
   localparam int STAGES = 2 * LOG2_LANES - 1,
   localparam int CW     = STAGES * SW,
   localparam int AW     = $clog2(ROUTE_DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           route_we,
   input  logic [AW-1:0]  route_addr,
   input  logic [CW-1:0]  route_data,
   input  logic           restart,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_data,
   output logic           out_valid,
   output logic [N*W-1:0] out_data
);
   if (LOG2_LANES < 1) begin : g_bad_lanes
      $error("benes_permuter: LOG2_LANES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("benes_permuter: W must be at least 1");
   end
   if (ROUTE_DEPTH < 2 || (ROUTE_DEPTH & (ROUTE_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("benes_permuter: ROUTE_DEPTH must be a power of two, at least 2");
   end

   logic [CW-1:0]  route;
   logic [N*W-1:0] lane_bus [STAGES+1];
   logic           vld_bus  [STAGES+1];

   benes_route_mem #(.DEPTH(ROUTE_DEPTH), .CW(CW)) u_routes (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (route_we),
      .waddr   (route_addr),
      .wdata   (route_data),
      .restart (restart),
      .advance (in_valid),
      .route   (route)
   );

   assign lane_bus[0] = in_data;
   assign vld_bus[0]  = in_valid;

   for (genvar s = 0; s < STAGES; s++) begin : g_col
      logic [SW-1:0] sel_s;

      benes_ctrl_delay #(.WIDTH(SW), .DLY(s)) u_dly (
         .clk (clk),
         .d   (route[s*SW +: SW]),
         .q   (sel_s)
      );

      benes_column #(.N(N), .W(W), .BIT(benes_pkg::col_bit(s, LOG2_LANES))) u_col (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (vld_bus[s]),
         .in_data   (lane_bus[s]),
         .sel       (sel_s),
         .out_valid (vld_bus[s+1]),
         .out_data  (lane_bus[s+1])
      );
   end

   assign out_valid = vld_bus[STAGES];
   assign out_data  = lane_bus[STAGES];

   // occupancy tracker for the latency checks
   localparam int OW = $clog2(STAGES + 2);
   logic [OW-1:0] in_flight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_flight <= '0;
      else        in_flight <= in_flight + OW'(in_valid) - OW'(out_valid);
   end

   p_flight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight <= OW'(STAGES));
   p_no_phantom_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_flight != '0));
   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |-> !out_valid);
endmodule

// File: tb/benes_permuter_test.sv
module benes_permuter_test;
   localparam int LG = 3;
   localparam int W  = 8;
   localparam int DEPTH = 16;
   localparam int N  = 1 << LG;
   localparam int SW = N / 2;
   localparam int ST = 2 * LG - 1;
   localparam int CW = ST * SW;
   localparam int AW = $clog2(DEPTH);

   logic           clk = 0;
   logic           rst_n = 0;
   logic           route_we = 0;
   logic [AW-1:0]  route_addr = '0;
   logic [CW-1:0]  route_data = '0;
   logic           restart = 0;
   logic           in_valid = 0;
   logic [N*W-1:0] in_data = '0;
   logic           out_valid;
   logic [N*W-1:0] out_data;

   benes_permuter #(.LOG2_LANES(LG), .W(W), .ROUTE_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .route_we(route_we), .route_addr(route_addr),
      .route_data(route_data), .restart(restart), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   int pcnt = 0;
   bit done = 0;
   always @(posedge clk) pcnt <= pcnt + 1;

   // bench copy of the route store
   logic [CW-1:0] m_route [DEPTH];
   int            m_kind  [DEPTH];
   bit            m_fresh [DEPTH];
   int            ptr_m = 0;
   bit            wrapped = 0;
   bit            post_reset = 0;

   bit            exp_v  [256];
   logic [N*W-1:0] exp_d [256];
   logic [N*W-1:0] exp_in[256];
   string         exp_tag[256];

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N*W-1:0] net_model(input logic [N*W-1:0] d, input logic [CW-1:0] r);
      logic [W-1:0] ln [N];
      logic [W-1:0] t;
      logic [N*W-1:0] o;
      for (int i = 0; i < N; i++) ln[i] = d[i*W +: W];
      for (int s = 0; s < ST; s++) begin
         int b;
         b = (s < LG) ? (LG - 1 - s) : (s - LG + 1);
         for (int k = 0; k < SW; k++) begin
            int lo, hi;
            lo = ((k >> b) << (b + 1)) | (k & ((1 << b) - 1));
            hi = lo + (1 << b);
            if (r[s*SW + k]) begin
               t = ln[lo]; ln[lo] = ln[hi]; ln[hi] = t;
            end
         end
      end
      for (int i = 0; i < N; i++) o[i*W +: W] = ln[i];
      return o;
   endfunction

   // expected result from the entry kind, written directly where possible
   function automatic logic [N*W-1:0] expect_of(input int e, input logic [N*W-1:0] d);
      logic [N*W-1:0] o;
      o = d;
      case (m_kind[e])
         1: o = d;
         2: for (int i = 0; i < N; i++) o[i*W +: W] = d[(N-1-i)*W +: W];
         3: for (int i = 0; i < N; i++) o[i*W +: W] = d[(i ^ 5)*W +: W];
         4: begin o[0 +: W] = d[4*W +: W]; o[4*W +: W] = d[0 +: W]; end
         default: o = net_model(d, m_route[e]);
      endcase
      return o;
   endfunction

   function automatic logic [N*W-1:0] make_vec();
      logic [7:0] base, step;
      logic [N*W-1:0] v;
      base = 8'($urandom);
      step = 8'($urandom) | 8'h01;
      for (int i = 0; i < N; i++) v[i*W +: W] = base + 8'(i) * step;
      return v;
   endfunction

   task automatic write_route(input int a, input logic [CW-1:0] r, input int kind, input bit fresh);
      @(negedge clk);
      in_valid = 0; restart = 0;
      route_we = 1; route_addr = AW'(a); route_data = r;
      m_route[a] = r; m_kind[a] = kind; m_fresh[a] = fresh;
   endtask

   task automatic drive(input bit v, input bit rs);
      logic [N*W-1:0] d;
      int idx, e;
      @(negedge clk);
      route_we = 0;
      d = make_vec();
      in_valid = v; restart = rs; in_data = d;
      if (rs) begin ptr_m = 0; wrapped = 0; end
      if (v) begin
         idx = pcnt & 255;
         e = ptr_m;
         exp_v[idx]  = 1;
         exp_in[idx] = d;
         exp_d[idx]  = expect_of(e, d);
         if (rs)                 exp_tag[idx] = "R9 restart uses entry 0";
         else if (post_reset)    exp_tag[idx] = "R10 pointer at 0 after reset";
         else if (m_fresh[e])    exp_tag[idx] = "R7 rewritten entry";
         else if (m_kind[e] == 1) exp_tag[idx] = "R1,R4 identity";
         else if (m_kind[e] == 2) exp_tag[idx] = "R4 reversal";
         else if (m_kind[e] == 3) exp_tag[idx] = "R2 address-bit xor";
         else if (m_kind[e] == 4) exp_tag[idx] = "R3 single cross";
         else if (e == 0 && wrapped) exp_tag[idx] = "R8 wrap to entry 0";
         else                    exp_tag[idx] = "R6 streamed route";
         m_fresh[e] = 0;
         post_reset = 0;
         ptr_m = (ptr_m + 1) % DEPTH;
         if (ptr_m == 0) wrapped = 1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; in_valid = 0; restart = 0; route_we = 0;
      for (int i = 0; i < 256; i++) exp_v[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      ptr_m = 0; wrapped = 0; post_reset = 1;
   endtask

   // output monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n && pcnt >= ST) begin
         int idx;
         idx = (pcnt - ST) & 255;
         check(out_valid == exp_v[idx], "R5 out_valid timing", 64'(out_valid), 64'(exp_v[idx]));
         if (exp_v[idx] && out_valid) begin
            check(out_data == exp_d[idx], exp_tag[idx], 64'(out_data), 64'(exp_d[idx]));
            begin
               bit ok;
               ok = 1;
               for (int j = 0; j < N; j++) begin
                  int hits;
                  hits = 0;
                  for (int i = 0; i < N; i++)
                     if (exp_in[idx][i*W +: W] == out_data[j*W +: W]) hits++;
                  if (hits != 1) ok = 0;
               end
               check(ok, "R11 each word once", 64'(out_data), 64'(exp_in[idx]));
            end
         end
         exp_v[idx] = 0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", pcnt, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0b1e));
      for (int i = 0; i < 256; i++) exp_v[i] = 0;
      for (int i = 0; i < DEPTH; i++) begin m_route[i] = '0; m_kind[i] = 0; m_fresh[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      post_reset = 1;
      @(negedge clk);
      check(out_valid == 0, "R10 out_valid low after reset", 64'(out_valid), 64'(0));

      // directed route table: identity, reversal, xor 5, one element, then random
      write_route(0, 20'h00000, 1, 0);
      write_route(1, 20'h00FFF, 2, 0);
      write_route(2, 20'h00F0F, 3, 0);
      write_route(3, 20'h00001, 4, 0);
      for (int i = 4; i < DEPTH; i++) write_route(i, CW'($urandom), 0, 0);
      post_reset = 1;

      // back-to-back, different route every cycle, through the wrap
      for (int i = 0; i < 20; i++) drive(1, 0);
      repeat (ST + 2) drive(0, 0);

      // gaps and a restart
      drive(1, 1);
      drive(1, 0);
      drive(0, 0);
      drive(1, 0);
      repeat (3) drive(0, 0);
      drive(1, 0);

      // rewrite an entry ahead of the pointer, then reach it
      write_route((ptr_m + 1) % DEPTH, CW'($urandom), 0, 1);
      drive(1, 0);
      drive(1, 0);
      drive(1, 0);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int c;
         c = $urandom_range(0, 99);
         if (c < 55)      drive(1, 0);
         else if (c < 65) drive(1, 1);
         else if (c < 85) drive(0, 0);
         else             write_route($urandom_range(0, DEPTH - 1), CW'($urandom), 0, 1);
      end
      repeat (ST + 2) drive(0, 0);

      // reset with vectors in flight: they must not come out
      drive(1, 0);
      drive(1, 0);
      do_reset();
      @(negedge clk);
      check(out_valid == 0, "R10 in-flight vectors dropped by reset", 64'(out_valid), 64'(0));
      drive(1, 0);
      drive(1, 0);
      repeat (ST + 3) drive(0, 0);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule